// File: doc/BRIEF.md
# Carrier Presence Detector with Drop-Out Holdoff

This block decides whether a line carrier is present from a stream of signal energy magnitudes that an upstream filter stage delivers, one per strobe. Each magnitude is compared against a threshold supplied from outside the block. A second, higher level is formed by adding a hysteresis margin to the threshold. Energy at or above the upper level declares the carrier present. Energy below the threshold declares it absent. Energy between the two levels keeps the last decision, so the status cannot chatter when the received level sits close to the threshold.

A raised status flag does not drop on the first absent decision. A counter tallies consecutive absent strobes. The flag falls only when the tally reaches a fixed delay length, so a short fade on the line is bridged. If the carrier comes back before the delay runs out, the tally clears and the flag stays raised. The block works only on magnitudes. How the energy is estimated from the analog signal is handled elsewhere.

Top module: `carrier_detect`

## Requirements
- R1: After reset the carrier flag is low and the holdoff tally is zero, so a first run of DELAY_STROBES-1 absent strobes after any later rise does not clear the flag.
- R2: A strobe whose energy is greater than or equal to threshold + margin is a "present" decision. The flag is high in the cycle after that strobe.
- R3: A strobe whose energy is strictly below threshold is an "absent" decision.
- R4: A strobe whose energy lies in the band [threshold, threshold + margin) repeats the previous decision. Before any decision has been made, the previous decision is taken as absent.
- R5: With the flag high, the flag goes low in the cycle after the DELAY_STROBES-th consecutive absent decision, and not earlier.
- R6: A present decision while the holdoff tally is running clears the tally and keeps the flag high. A later drop-out then needs a full DELAY_STROBES absent decisions again.
- R7: Cycles without a strobe change nothing, whatever the energy, threshold and margin inputs carry.
- R8: The sum threshold + margin is formed without wrap-around. When it exceeds the largest representable energy, no sample can be a present decision.
- R9: While the flag is low, absent decisions leave the tally at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Strobe that marks a new energy sample |
| energy | input | ENERGY_W | Energy magnitude of the current sample |
| threshold | input | ENERGY_W | Lower decision level (absent below it) |
| margin | input | MARGIN_W | Hysteresis added to threshold to form the upper level |
| carrier_flag | output | 1 | Carrier status: 1 = present, 0 = carrier failure |

## Verification
The assertions check on every cycle that idle cycles freeze both the decision and the tally, that a present decision raises the flag and clears the tally, that the flag only falls on the strobe where the tally expires, and that the tally stays within range and is zero whenever the flag is low. Only the bench's scenarios can show that the fall happens after exactly DELAY_STROBES absent strobes, that the band levels near threshold and threshold + margin land on the right side, and that a saturated upper level never declares presence. They can also show that a carrier returning partway through a fade restarts the whole delay.

// File: rtl/carrier_det_pkg.sv
package carrier_det_pkg;

  // Upper level test, done one bit wider so threshold + margin cannot wrap.
  function automatic logic level_high(input logic [31:0] e, input logic [31:0] t,
                                      input logic [31:0] m);
    logic [32:0] sum;
    sum = {1'b0, t} + {1'b0, m};
    return ({1'b0, e} >= sum);
  endfunction

  // Lower level test.
  function automatic logic level_low(input logic [31:0] e, input logic [31:0] t);
    return (e < t);
  endfunction

endpackage

// File: rtl/cd_compare.sv
module cd_compare #(
  parameter int ENERGY_W = 16,
  parameter int MARGIN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_valid,
  input  logic [ENERGY_W-1:0] energy,
  input  logic [ENERGY_W-1:0] threshold,
  input  logic [MARGIN_W-1:0] margin,
  output logic                det_on,
  output logic                det_off,
  output logic                decision
);
  import carrier_det_pkg::*;

  logic det_q;

  always_comb begin
    det_on  = level_high(32'(energy), 32'(threshold), 32'(margin));
    det_off = level_low(32'(energy), 32'(threshold));
    if (det_on)       decision = 1'b1;
    else if (det_off) decision = 1'b0;
    else              decision = det_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            det_q <= 1'b0;
    else if (sample_valid) det_q <= decision;
  end

  // R4: a band sample keeps the stored decision
  p_band_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !det_on && !det_off) |=> (det_q == $past(det_q)));

  // R7: no strobe, no decision change
  p_idle_decision_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(det_q));

endmodule

// File: rtl/cd_holdoff.sv
module cd_holdoff #(
  parameter int DELAY_STROBES = 8,
  localparam int CNT_W = $clog2(DELAY_STROBES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_valid,
  input  logic decision,
  output logic flag
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_STROBES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             cnt_expire;
  logic             absent_step;

  assign absent_step = sample_valid && !decision && flag_q;
  assign cnt_expire  = absent_step && (cnt_q == LAST);
  assign flag        = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sample_valid) begin
      if (decision) begin
        flag_q <= 1'b1;
        cnt_q  <= '0;
      end else if (cnt_expire) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else if (absent_step) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R2 / R6: a present decision raises the flag and clears the tally
  p_present_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && decision) |=> (flag_q && cnt_q == '0));

  // R5: the flag only falls on the expiring strobe
  p_fall_on_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !cnt_expire) |=> flag_q);

  // R5: tally never passes the last step
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: tally is zero whenever the flag is low
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q |-> (cnt_q == '0));

  // R7: no strobe, no state change
  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> ($stable(flag_q) && $stable(cnt_q)));

endmodule

// File: rtl/carrier_detect.sv
module carrier_detect #(
  parameter int ENERGY_W      = 16,
  parameter int MARGIN_W      = 8,
  parameter int DELAY_STROBES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_valid,
  input  logic [ENERGY_W-1:0] energy,
  input  logic [ENERGY_W-1:0] threshold,
  input  logic [MARGIN_W-1:0] margin,
  output logic                carrier_flag
);
  logic det_on;
  logic det_off;
  logic decision;

  initial begin
    if (DELAY_STROBES < 1) $error("DELAY_STROBES must be at least 1");
    if (ENERGY_W > 32 || MARGIN_W > 32) $error("widths limited to 32 bits");
  end

  cd_compare #(.ENERGY_W(ENERGY_W), .MARGIN_W(MARGIN_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .energy(energy), .threshold(threshold), .margin(margin),
    .det_on(det_on), .det_off(det_off), .decision(decision)
  );

  cd_holdoff #(.DELAY_STROBES(DELAY_STROBES)) u_hold (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .decision(decision), .flag(carrier_flag)
  );

  // R3: below threshold is never a present decision
  p_low_not_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    det_off |-> !det_on);

  // R8: an upper level past full scale cannot declare presence
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((33'(threshold) + 33'(margin)) > 33'({ENERGY_W{1'b1}})) |-> !det_on);

endmodule

// File: tb/carrier_detect_tb.sv
module carrier_detect_tb;
  localparam int EW = 16;
  localparam int MW = 8;
  localparam int DLY = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_valid = 1'b0;
  logic [EW-1:0] energy = '0;
  logic [EW-1:0] threshold = '0;
  logic [MW-1:0] margin = '0;
  logic          carrier_flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model state
  bit m_det = 1'b0;
  bit m_flag = 1'b0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  carrier_detect #(.ENERGY_W(EW), .MARGIN_W(MW), .DELAY_STROBES(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .energy(energy),
    .threshold(threshold), .margin(margin), .carrier_flag(carrier_flag)
  );

  function automatic int classify(int e, int t, int m);
    if (e >= t + m) return 1;   // present
    if (e < t)      return 0;   // absent
    return 2;                   // band
  endfunction

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: carrier_flag=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // one strobe, then compare one cycle later
  task automatic strobe(int e, int t, int m, string tag);
    int c;
    bit d;
    @(negedge clk);
    sample_valid = 1'b1;
    energy = EW'(e); threshold = EW'(t); margin = MW'(m);
    c = classify(e, t, m);
    d = (c == 2) ? m_det : (c == 1);
    m_det = d;
    if (d) begin m_flag = 1'b1; m_cnt = 0; end
    else if (m_flag) begin
      if (m_cnt == DLY - 1) begin m_flag = 1'b0; m_cnt = 0; end
      else m_cnt++;
    end
    @(negedge clk);
    sample_valid = 1'b0;
    check(tag, carrier_flag, m_flag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_valid = 1'b0;
      energy = EW'($urandom); threshold = EW'($urandom); margin = MW'($urandom);
    end
    @(negedge clk);
    check(tag, carrier_flag, m_flag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, flag=%0b expected completion", carrier_flag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset", carrier_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", carrier_flag, 1'b0);

    // R4: band before any decision counts as absent
    strobe(1005, 1000, 20, "R4 initial band");
    // R2: exact upper level
    strobe(1020, 1000, 20, "R2 rise at threshold+margin");
    // R1 / R5: exactly DLY absent strobes needed
    for (int i = 0; i < DLY - 1; i++) strobe(999, 1000, 20, "R5 hold during delay");
    strobe(999, 1000, 20, "R5 fall on last strobe");
    // R9: absent while low keeps tally zero; rise then DLY-1 keeps high
    strobe(10, 1000, 20, "R9 absent while low");
    strobe(10, 1000, 20, "R9 absent while low");
    strobe(5000, 1000, 20, "R2 rise");
    for (int i = 0; i < DLY - 1; i++) strobe(10, 1000, 20, "R9 tally started at zero");
    // R6: return during delay restarts full delay
    strobe(3000, 1000, 20, "R6 return during delay");
    for (int i = 0; i < DLY - 1; i++) strobe(10, 1000, 20, "R6 full delay again");
    strobe(10, 1000, 20, "R6 fall after full delay");
    // R4: band just under upper level while absent stays low
    strobe(1019, 1000, 20, "R4 band below upper level");
    strobe(1030, 1000, 20, "R2 rise");
    // R3 / R4: band at threshold holds present, one below counts
    for (int i = 0; i < 10; i++) strobe(1000, 1000, 20, "R4 band at threshold holds");
    strobe(999, 1000, 20, "R3 below threshold counts");
    // R7: idle cycles with loud energy
    idle(25, "R7 idle ignored");
    for (int i = 0; i < DLY - 2; i++) strobe(0, 1000, 20, "R3 absent");
    idle(10, "R7 idle ignored mid-delay");
    strobe(0, 1000, 20, "R5 fall after idle gap");
    idle(10, "R7 idle ignored while low");
    // R8: saturated upper level
    strobe(65535, 65535, 1, "R8 no wrap full scale");
    strobe(65535, 65500, 200, "R8 no wrap sum overflow");
    strobe(65535, 65535, 0, "R2 full scale zero margin");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int t, m, e, c;
      t = int'($urandom_range(200, 60000));
      m = int'($urandom_range(0, 255));
      c = int'($urandom_range(0, 9));
      if (c < 4)      e = t - int'($urandom_range(1, 200));
      else if (c < 7) e = t + m + int'($urandom_range(0, 200));
      else            e = t + ((m > 0) ? int'($urandom_range(0, m - 1)) : 0);
      if (e < 0) e = 0;
      if (e > 65535) e = 65535;
      if (m == 0 && c >= 7) e = t;
      strobe(e, t, m, (classify(e, t, m) == 2) ? "R4 random" : "R5 random");
      if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 4)), "R7 random idle");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule